// File: doc/BRIEF.md
# Interval Timer and Trap Entry Sequencer

This block pairs a microsecond down-counter with the control logic that moves a processor into and out of an interrupt handler. The counter is loaded by a write, counts down once per 1 MHz tick enable while it is nonzero, and raises a timer event only when it steps from 1 to 0. Four causes compete for entry: a system call, the timer event, a disk-completion pulse, and a program error that carries a 2-bit code. The timer and disk causes are held in pending flags and can be masked by the current status word. The system call and the program error are synchronous and are taken in the cycle they are requested.

When a cause is accepted, the sequencer copies the current status word and next-instruction address into shadow registers. For a program error it also loads the parameter register. It then presents a handler address built from the vector-area base plus a per-cause offset, together with an all-zero status word, and pulses a redirect strobe for one cycle. A return-from-interrupt request presents the shadowed address and status word instead. All pins are plain control and status signals; there is no stream interface and no back-pressure. The surrounding core must act on every redirect pulse.

Top module: `trap_sequencer`

## Requirements
- R1: While the timer is nonzero and not being written, each cycle with `tick_us` high decrements it by one; at zero it stays at zero.
- R2: A timer write loads `tmr_wdata` on the next edge, takes priority over a tick in the same cycle, and discards any timer event not yet taken.
- R3: A timer event is raised only when the count steps from 1 to 0 on a tick; loading or holding zero never raises one.
- R4: On acceptance, `saved_psw` and `saved_ia` take the `cur_psw` and `cur_ia` of the request cycle, and one edge later `redirect` pulses for one cycle with `new_psw` all zeros.
- R5: A program-error entry writes its code, zero-extended, into `int_param` (0 undefined instruction, 1 privileged instruction in user mode, 2 bound violation); other causes leave `int_param` unchanged.
- R6: `new_ia` on entry is `vec_base` plus 4 times the cause number: system call 0, timer 1, disk 2, program error 3.
- R7: Priority is program error, then system call, then timer, then disk. A losing synchronous request is dropped. A losing pending cause stays pending and is taken on a later cycle.
- R8: While `cur_psw` bit 0 is 1, timer and disk events are kept pending and not taken. They are delivered once bit 0 is 0.
- R9: `rfi` makes `new_ia`/`new_psw` equal `saved_ia`/`saved_psw` with a redirect pulse one edge later. No cause is taken in an `rfi` cycle: synchronous requests in that cycle are dropped, and a pending unmasked cause is taken on the next cycle.
- R10: After reset the timer is 0, nothing is pending, `redirect` is low and every output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | 1 MHz count enable |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wdata | input | TW | Timer load value |
| req_syscall | input | 1 | System-call request (synchronous) |
| req_perr | input | 1 | Program-error request (synchronous) |
| perr_code | input | 2 | Program-error code |
| req_disk | input | 1 | Disk-completion pulse |
| rfi | input | 1 | Return-from-interrupt request |
| cur_ia | input | XLEN | Current next-instruction address |
| cur_psw | input | XLEN | Current status word; bit 0 masks timer and disk |
| vec_base | input | XLEN | Vector-area base address |
| new_ia | output | XLEN | Redirect target address |
| new_psw | output | XLEN | Status word to install on redirect |
| redirect | output | 1 | One-cycle strobe: apply new_ia/new_psw |
| saved_ia | output | XLEN | Shadowed next-instruction address |
| saved_psw | output | XLEN | Shadowed status word |
| int_param | output | XLEN | Interrupt parameter register |
| tmr_count | output | TW | Current timer value |

## Verification
The assertions check on every cycle the step-by-one countdown, the floor at zero, the load on write, the way the shadow registers and zeroed status word follow a synchronous entry, the program-error vector and parameter, the restore on return, and the absence of a redirect while masked with no synchronous request. The bench scenarios cover the behaviour that unfolds over several cycles or depends on history. These are the one-cycle delay between a timer's 1-to-0 step and its delivery, the order in which two masked causes drain once unmasked, a write discarding a pending timer event, a zero load never firing, and a pending cause waiting out an `rfi` cycle while a simultaneous system call is lost.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    CAUSE_SYSCALL = 2'd0,
    CAUSE_TIMER   = 2'd1,
    CAUSE_DISK    = 2'd2,
    CAUSE_PERR    = 2'd3
  } cause_e;

  localparam int VEC_SHIFT = 2;  // 4-byte vector slots
  localparam int MASK_BIT  = 0;  // status-word bit that masks timer and disk
endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] count,
  output logic          expire
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic nonzero;
  assign nonzero = |count;
  // the 1-to-0 step is the only event source
  assign expire  = tick && !wr && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (wr)
      count <= wdata;
    else if (tick && nonzero)
      count <= count - ONE;
  end
endmodule

// File: rtl/cause_arbiter.sv
module cause_arbiter
  import trap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sys_req,
  input  logic   perr_req,
  input  logic   tmr_evt,
  input  logic   tmr_clr,
  input  logic   disk_evt,
  input  logic   masked,
  input  logic   hold,
  output logic   take,
  output cause_e cause
);
  logic pend_tmr, pend_disk;
  logic tmr_ok, disk_ok;

  assign tmr_ok  = pend_tmr  && !masked;
  assign disk_ok = pend_disk && !masked;

  always_comb begin
    take  = 1'b0;
    cause = CAUSE_SYSCALL;
    if (!hold) begin
      if (perr_req) begin
        take = 1'b1; cause = CAUSE_PERR;
      end else if (sys_req) begin
        take = 1'b1; cause = CAUSE_SYSCALL;
      end else if (tmr_ok) begin
        take = 1'b1; cause = CAUSE_TIMER;
      end else if (disk_ok) begin
        take = 1'b1; cause = CAUSE_DISK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tmr  <= 1'b0;
      pend_disk <= 1'b0;
    end else begin
      if (tmr_clr)
        pend_tmr <= 1'b0;
      else
        pend_tmr <= (pend_tmr && !(take && cause == CAUSE_TIMER)) || tmr_evt;
      // a new pulse wins over the clear of the one being taken
      pend_disk <= (pend_disk && !(take && cause == CAUSE_DISK)) || disk_evt;
    end
  end
endmodule

// File: rtl/entry_regs.sv
module entry_regs
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  cause_e          cause,
  input  logic            rfi,
  input  logic [1:0]      perr_code,
  input  logic [XLEN-1:0] cur_ia,
  input  logic [XLEN-1:0] cur_psw,
  input  logic [XLEN-1:0] vec_base,
  output logic [XLEN-1:0] new_ia,
  output logic [XLEN-1:0] new_psw,
  output logic            redirect,
  output logic [XLEN-1:0] iia,
  output logic [XLEN-1:0] ipsw,
  output logic [XLEN-1:0] ip
);
  logic [XLEN-1:0] vec_off;
  assign vec_off = XLEN'(cause) << VEC_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_ia   <= '0;
      new_psw  <= '0;
      redirect <= 1'b0;
      iia      <= '0;
      ipsw     <= '0;
      ip       <= '0;
    end else begin
      redirect <= 1'b0;
      if (rfi) begin
        new_ia   <= iia;
        new_psw  <= ipsw;
        redirect <= 1'b1;
      end else if (take) begin
        iia      <= cur_ia;
        ipsw     <= cur_psw;
        if (cause == CAUSE_PERR)
          ip <= XLEN'(perr_code);
        new_ia   <= vec_base + vec_off;
        new_psw  <= '0;
        redirect <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int TW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_us,
  input  logic            tmr_wr,
  input  logic [TW-1:0]   tmr_wdata,
  input  logic            req_syscall,
  input  logic            req_perr,
  input  logic [1:0]      perr_code,
  input  logic            req_disk,
  input  logic            rfi,
  input  logic [XLEN-1:0] cur_ia,
  input  logic [XLEN-1:0] cur_psw,
  input  logic [XLEN-1:0] vec_base,
  output logic [XLEN-1:0] new_ia,
  output logic [XLEN-1:0] new_psw,
  output logic            redirect,
  output logic [XLEN-1:0] saved_ia,
  output logic [XLEN-1:0] saved_psw,
  output logic [XLEN-1:0] int_param,
  output logic [TW-1:0]   tmr_count
);
  logic   tmr_expire;
  logic   take;
  cause_e cause;

  tick_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_us),
    .wr     (tmr_wr),
    .wdata  (tmr_wdata),
    .count  (tmr_count),
    .expire (tmr_expire)
  );

  cause_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_req  (req_syscall),
    .perr_req (req_perr),
    .tmr_evt  (tmr_expire),
    .tmr_clr  (tmr_wr),
    .disk_evt (req_disk),
    .masked   (cur_psw[MASK_BIT]),
    .hold     (rfi),
    .take     (take),
    .cause    (cause)
  );

  entry_regs #(.XLEN(XLEN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .cause     (cause),
    .rfi       (rfi),
    .perr_code (perr_code),
    .cur_ia    (cur_ia),
    .cur_psw   (cur_psw),
    .vec_base  (vec_base),
    .new_ia    (new_ia),
    .new_psw   (new_psw),
    .redirect  (redirect),
    .iia       (saved_ia),
    .ipsw      (saved_psw),
    .ip        (int_param)
  );
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
  parameter int XLEN = 32,
  parameter int TW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_us,
  input logic            tmr_wr,
  input logic [TW-1:0]   tmr_wdata,
  input logic            req_syscall,
  input logic            req_perr,
  input logic [1:0]      perr_code,
  input logic            rfi,
  input logic [XLEN-1:0] cur_ia,
  input logic [XLEN-1:0] cur_psw,
  input logic [XLEN-1:0] vec_base,
  input logic [XLEN-1:0] new_ia,
  input logic [XLEN-1:0] new_psw,
  input logic            redirect,
  input logic [XLEN-1:0] saved_ia,
  input logic [XLEN-1:0] saved_psw,
  input logic [XLEN-1:0] int_param,
  input logic [TW-1:0]   tmr_count
);
  // R1
  tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_us && !tmr_wr && tmr_count != '0) |=> (tmr_count == $past(tmr_count) - TW'(1)));

  // R1
  tmr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && tmr_count == '0) |=> (tmr_count == '0));

  // R2
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> (tmr_count == $past(tmr_wdata)));

  // R4
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_syscall && !rfi) |=> (redirect && saved_ia == $past(cur_ia)
                               && saved_psw == $past(cur_psw) && new_psw == '0));

  // R5 R6
  perr_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_perr && !rfi) |=> (new_ia == $past(vec_base) + XLEN'(12)
                            && int_param == XLEN'($past(perr_code))));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_psw[0] && !rfi && !req_syscall && !req_perr) |=> !redirect);

  // R9
  rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfi |=> (redirect && new_ia == $past(saved_ia) && new_psw == $past(saved_psw)));
endmodule

bind trap_sequencer trap_sequencer_chk #(.XLEN(XLEN), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_us     (tick_us),
  .tmr_wr      (tmr_wr),
  .tmr_wdata   (tmr_wdata),
  .req_syscall (req_syscall),
  .req_perr    (req_perr),
  .perr_code   (perr_code),
  .rfi         (rfi),
  .cur_ia      (cur_ia),
  .cur_psw     (cur_psw),
  .vec_base    (vec_base),
  .new_ia      (new_ia),
  .new_psw     (new_psw),
  .redirect    (redirect),
  .saved_ia    (saved_ia),
  .saved_psw   (saved_psw),
  .int_param   (int_param),
  .tmr_count   (tmr_count)
);

// File: tb/trap_sequencer_test.sv
`timescale 1ns/1ps
module trap_sequencer_test;
  localparam int XLEN = 32;
  localparam int TW   = 32;
  localparam logic [XLEN-1:0] VB = 32'h0000_8000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick_us = 1'b0, tmr_wr = 1'b0;
  logic [TW-1:0]   tmr_wdata = '0;
  logic            req_syscall = 1'b0, req_perr = 1'b0, req_disk = 1'b0, rfi = 1'b0;
  logic [1:0]      perr_code = '0;
  logic [XLEN-1:0] cur_ia = '0, cur_psw = '0, vec_base = VB;
  logic [XLEN-1:0] new_ia, new_psw, saved_ia, saved_psw, int_param;
  logic            redirect;
  logic [TW-1:0]   tmr_count;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  trap_sequencer #(.XLEN(XLEN), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .req_syscall(req_syscall), .req_perr(req_perr), .perr_code(perr_code),
    .req_disk(req_disk), .rfi(rfi), .cur_ia(cur_ia), .cur_psw(cur_psw),
    .vec_base(vec_base), .new_ia(new_ia), .new_psw(new_psw), .redirect(redirect),
    .saved_ia(saved_ia), .saved_psw(saved_psw), .int_param(int_param),
    .tmr_count(tmr_count)
  );

  typedef struct packed {
    logic        sys;
    logic        perr;
    logic [1:0]  code;
    logic [15:0] ia;
    logic [3:0]  psw;
    logic [3:0]  exp_off;
    logic [1:0]  exp_ip;
  } vec_t;

  // synchronous entries: offsets per R6, parameter per R5, priority per R7
  localparam vec_t TABLE [6] = '{
    '{1'b0, 1'b1, 2'd0, 16'h1000, 4'h1, 4'd12, 2'd0},
    '{1'b1, 1'b0, 2'd0, 16'h1004, 4'h0, 4'd0,  2'd0},
    '{1'b0, 1'b1, 2'd2, 16'h2000, 4'h3, 4'd12, 2'd2},
    '{1'b1, 1'b1, 2'd1, 16'h3000, 4'h0, 4'd12, 2'd1},
    '{1'b1, 1'b0, 2'd3, 16'h3008, 4'h1, 4'd0,  2'd1},
    '{1'b0, 1'b1, 2'd1, 16'h4000, 4'h2, 4'd12, 2'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic watch(input int n, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (redirect) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) cyc();
    // R10 reset state
    chk("R10 count", tmr_count, 0);
    chk("R10 redirect", {31'b0, redirect}, 0);
    chk("R10 new_ia", new_ia, 0);
    chk("R10 param", int_param, 0);
    rst_n = 1'b1;
    cyc();

    for (int k = 0; k < 6; k++) begin
      req_syscall = TABLE[k].sys;
      req_perr    = TABLE[k].perr;
      perr_code   = TABLE[k].code;
      cur_ia      = {16'h0, TABLE[k].ia};
      cur_psw     = {28'h0, TABLE[k].psw};
      cyc();
      req_syscall = 1'b0; req_perr = 1'b0;
      chk("R4 redirect", {31'b0, redirect}, 1);
      chk("R4 saved_ia", saved_ia, {16'h0, TABLE[k].ia});
      chk("R4 saved_psw", saved_psw, {28'h0, TABLE[k].psw});
      chk("R4 new_psw", new_psw, 0);
      chk("R6 R7 new_ia", new_ia, VB + {28'h0, TABLE[k].exp_off});
      chk("R5 param", int_param, {30'h0, TABLE[k].exp_ip});
      cyc();
      chk("R4 pulse", {31'b0, redirect}, 0);
    end

    // R1 R3: countdown and delayed delivery of the 1-to-0 event
    cur_psw = '0;
    tmr_wr = 1'b1; tmr_wdata = 3; cyc(); tmr_wr = 1'b0;
    chk("R2 load", tmr_count, 3);
    tick_us = 1'b1;
    cyc(); chk("R1 dec", tmr_count, 2);
    cyc(); cyc();
    chk("R1 reach0", tmr_count, 0);
    chk("R3 no early redirect", {31'b0, redirect}, 0);
    cyc();
    chk("R3 timer redirect", {31'b0, redirect}, 1);
    chk("R6 timer vec", new_ia, VB + 4);
    chk("R1 floor", tmr_count, 0);
    tick_us = 1'b0;
    cyc();

    // R3 loading zero never fires
    tmr_wr = 1'b1; tmr_wdata = 0; cyc(); tmr_wr = 1'b0;
    tick_us = 1'b1; watch(4, seen); tick_us = 1'b0;
    chk("R3 zero load no event", {31'b0, seen}, 0);

    // R8 R7: masked timer and disk, drained in priority order
    cur_psw = 32'h1;
    tmr_wr = 1'b1; tmr_wdata = 1; cyc(); tmr_wr = 1'b0;
    tick_us = 1'b1; cyc(); tick_us = 1'b0;
    req_disk = 1'b1; cyc(); req_disk = 1'b0;
    watch(3, seen);
    chk("R8 masked hold", {31'b0, seen}, 0);
    cur_psw = 32'h0;
    cyc();
    chk("R8 deliver", {31'b0, redirect}, 1);
    chk("R7 timer first", new_ia, VB + 4);
    cyc();
    chk("R7 disk next", {31'b0, redirect}, 1);
    chk("R7 disk vec", new_ia, VB + 8);
    cyc();
    chk("R7 drained", {31'b0, redirect}, 0);

    // R2 write discards pending event and beats a tick
    cur_psw = 32'h1;
    tmr_wr = 1'b1; tmr_wdata = 1; cyc(); tmr_wr = 1'b0;
    tick_us = 1'b1; cyc(); tick_us = 1'b0;
    tmr_wr = 1'b1; tmr_wdata = 5; cyc(); tmr_wr = 1'b0;
    chk("R2 reload", tmr_count, 5);
    cur_psw = 32'h0;
    watch(3, seen);
    chk("R2 pending discarded", {31'b0, seen}, 0);
    tmr_wr = 1'b1; tmr_wdata = 7; tick_us = 1'b1; cyc();
    tmr_wr = 1'b0; tick_us = 1'b0;
    chk("R2 write over tick", tmr_count, 7);
    tmr_wr = 1'b1; tmr_wdata = 0; cyc(); tmr_wr = 1'b0;

    // R9 return restores shadows
    cur_ia = 32'hA0; cur_psw = 32'h4;
    req_syscall = 1'b1; cyc(); req_syscall = 1'b0;
    cur_ia = 32'h5555; cur_psw = 32'h1;
    cyc();
    rfi = 1'b1; cyc(); rfi = 1'b0;
    chk("R9 redirect", {31'b0, redirect}, 1);
    chk("R9 ia", new_ia, 32'hA0);
    chk("R9 psw", new_psw, 32'h4);

    // R9 rfi blocks takes: pending waits a cycle, syscall is lost
    req_disk = 1'b1; cyc(); req_disk = 1'b0;
    cur_psw = 32'h0;
    rfi = 1'b1; req_syscall = 1'b1; cyc(); rfi = 1'b0; req_syscall = 1'b0;
    chk("R9 restore wins", new_ia, 32'hA0);
    cyc();
    chk("R9 pending next", {31'b0, redirect}, 1);
    chk("R9 disk vec", new_ia, VB + 8);
    cyc();
    chk("R9 syscall dropped", {31'b0, redirect}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule